// File: doc/BRIEF.md
# Modular Halving Correction Unit

This unit finishes a modular inversion. It takes an intermediate residue r = x^-1·2^z mod p from an earlier binary-GCD stage and removes factors of two by halving modulo p, one step per clock. Each step looks at the current value. An even value is shifted right by one bit. For an odd value, the odd modulus p is added first and the (K+1)-bit sum is then shifted right. Every step is a division by two modulo p.

The number of steps depends on the data and is selected by a mode input. In classical mode the unit halves z times and returns x^-1 mod p. In Montgomery-domain mode it halves z−K times and returns x^-1·2^K mod p. In that mode a later Montgomery product with 2^2K mod p finishes the conversion, and that product is not part of this block. The exponent from the earlier stage always lies in [K, 2K].

A one-cycle start pulse latches r, p, z and the mode. Busy stays high while steps remain. A one-cycle done pulse marks the point where the result register is loaded, and the result register then holds its value until the next accepted start.

Top module: `modhalf_corr`

## Requirements
- R1: While reset is asserted and right after it, busy and done read 0 and result reads 0.
- R2: A step on an even current value yields the value shifted right by one bit.
- R3: A step on an odd current value yields (value + p) / 2. The sum is formed K+1 bits wide, so r = p−2 with p = 65521 gives 65520.
- R4: With mode = 0 (classical), the unit performs exactly z steps and the result equals x^-1 mod p.
- R5: With mode = 1 (Montgomery domain), the unit performs exactly z−K steps and the result equals x^-1·2^K mod p.
- R6: When the step count is zero (mode = 1, z = K), r passes unchanged to result, and done is high in the cycle right after the start edge.
- R7: For a step count n ≥ 1, busy is high from the start edge until done, and done is a single-cycle pulse raised n clock edges after the edge that samples start. Busy is low while done is high.
- R8: Result keeps its value from one done until the next accepted start, whatever the data inputs do.
- R9: A start pulse that arrives while busy is high is ignored. The running operation keeps its operands, latency and result.
- R10: For an input r < p, every result is less than p, and no final subtraction is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when not busy |
| mode | input | 1 | 0 = classical inverse (z steps), 1 = Montgomery domain (z−K steps) |
| p_in | input | K | Odd modulus |
| r_in | input | K | Residue x^-1·2^z mod p, below p |
| z_in | input | clog2(2K+1) | Exponent z from the earlier stage, K ≤ z ≤ 2K |
| busy | output | 1 | Halving steps in progress |
| done | output | 1 | One-cycle pulse when result is loaded |
| result | output | K | Corrected residue, held until the next start |

## Verification
On every cycle the assertions check the single halving step for even and odd values, the countdown that makes the step count exact, the exclusion between done and busy, that the result holds between completions, that a start during a run does not disturb it, and that every finished result stays below the modulus. Only the bench scenarios can show that the whole chain of steps yields the true modular inverse in each mode, and that the latency equals z or z−K. These scenarios build residues from a reference inverse computation and also check that result times x reduces to 1 or 2^K modulo p.

// File: rtl/modhalf_pkg.sv
package modhalf_pkg;

  typedef enum logic {
    MODE_CLASSIC = 1'b0,
    MODE_MONT    = 1'b1
  } inv_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/modhalf_step.sv
// One modular halving: val/2 mod p for odd p and val < p.
module modhalf_step #(
  parameter int K = 256
) (
  input  logic [K-1:0] val,
  input  logic [K-1:0] modulus,
  output logic [K-1:0] halved
);
  localparam int SW = K + 1;

  logic [SW-1:0] addend;
  logic [SW-1:0] sum;

  always_comb begin
    addend = val[0] ? {1'b0, modulus} : '0;
    sum    = {1'b0, val} + addend;
    halved = sum[SW-1:1];
  end
endmodule

// File: rtl/modhalf_count.sv
// Step counter: loads z or z-K, counts down one per step.
module modhalf_count #(
  parameter int K  = 256,
  parameter int ZW = $clog2(2 * K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          mode,
  input  logic [ZW-1:0] z,
  output logic [ZW-1:0] cnt_q,
  output logic          zero_ld,
  output logic          last
);
  import modhalf_pkg::*;

  localparam logic [ZW-1:0] KZ = ZW'(K);

  logic [ZW-1:0] load_val;
  logic [ZW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    load_val = (inv_mode_e'(mode) == MODE_MONT) ? (z - KZ) : z;
    zero_ld  = (load_val == '0);
    last     = (cnt_q == ZW'(1));
    cnt_en   = load | step;
    cnt_d    = load ? load_val : (cnt_q - ZW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/modhalf_ctrl.sv
// Sequencer: accepts start when idle, runs steps, emits done pulse.
module modhalf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_ld,
  input  logic last,
  output logic load,
  output logic step,
  output logic fin_pass,
  output logic fin_step,
  output logic busy,
  output logic done
);
  import modhalf_pkg::*;

  seq_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    step     = 1'b0;
    fin_pass = 1'b0;
    fin_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (zero_ld) begin
            fin_pass = 1'b1;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (last) begin
          fin_step = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = fin_pass | fin_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/modhalf_corr.sv
// Top: operand registers, halving datapath, result register.
module modhalf_corr #(
  parameter int K  = 256,
  parameter int ZW = $clog2(2 * K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [K-1:0]  p_in,
  input  logic [K-1:0]  r_in,
  input  logic [ZW-1:0] z_in,
  output logic          busy,
  output logic          done,
  output logic [K-1:0]  result
);
  logic [K-1:0]  acc_q, acc_d;
  logic [K-1:0]  p_q;
  logic [K-1:0]  res_d;
  logic [K-1:0]  half;
  logic [ZW-1:0] cnt_q;
  logic          load, step, fin_pass, fin_step, zero_ld, last;
  logic          acc_en, res_en;

  modhalf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .zero_ld  (zero_ld),
    .last     (last),
    .load     (load),
    .step     (step),
    .fin_pass (fin_pass),
    .fin_step (fin_step),
    .busy     (busy),
    .done     (done)
  );

  modhalf_count #(.K(K), .ZW(ZW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .mode    (mode),
    .z       (z_in),
    .cnt_q   (cnt_q),
    .zero_ld (zero_ld),
    .last    (last)
  );

  modhalf_step #(.K(K)) u_step (
    .val     (acc_q),
    .modulus (p_q),
    .halved  (half)
  );

  always_comb begin
    acc_en = load | step;
    acc_d  = load ? r_in : half;
    res_en = fin_pass | fin_step;
    res_d  = fin_pass ? r_in : half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (load) begin
      p_q <= p_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (res_en) begin
      result <= res_d;
    end
  end
endmodule

// File: rtl/modhalf_corr_chk.sv
module modhalf_corr_chk #(
  parameter int K  = 256,
  parameter int ZW = $clog2(2 * K + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [K-1:0]  result,
  input logic [K-1:0]  acc_q,
  input logic [K-1:0]  p_q,
  input logic [ZW-1:0] cnt_q
);
  assert_even_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > ZW'(1) && !acc_q[0]) |=> (acc_q == ($past(acc_q) >> 1)));

  assert_odd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > ZW'(1) && acc_q[0]) |=>
      ({acc_q, 1'b0} == ({1'b0, $past(acc_q)} + {1'b0, $past(p_q)})));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > ZW'(1)) |=> (busy && cnt_q == $past(cnt_q) - ZW'(1)));

  assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == ZW'(1)) |=> (done && !busy));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (done || $stable(result)));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q > ZW'(1)) |=> (busy && $stable(p_q)));

  assert_below_mod_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < p_q));
endmodule

bind modhalf_corr modhalf_corr_chk #(.K(K), .ZW(ZW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .acc_q  (acc_q),
  .p_q    (p_q),
  .cnt_q  (cnt_q)
);

// File: tb/modhalf_corr_bench.sv
module modhalf_corr_bench;
  localparam int K          = 16;
  localparam int ZW         = $clog2(2 * K + 1);
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  // {mode, z[5:0], pad, p[15:0], x[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 6'd16, 1'b0, 16'd65521, 16'd3},
    {1'b0, 6'd32, 1'b0, 16'd65521, 16'd12345},
    {1'b0, 6'd23, 1'b0, 16'd65519, 16'd40000},
    {1'b0, 6'd17, 1'b0, 16'd251,   16'd7},
    {1'b0, 6'd31, 1'b0, 16'd257,   16'd256},
    {1'b0, 6'd20, 1'b0, 16'd3,     16'd2},
    {1'b1, 6'd16, 1'b0, 16'd65521, 16'd5},
    {1'b1, 6'd32, 1'b0, 16'd65519, 16'd999},
    {1'b1, 6'd24, 1'b0, 16'd65521, 16'd65520},
    {1'b1, 6'd17, 1'b0, 16'd251,   16'd250},
    {1'b1, 6'd29, 1'b0, 16'd257,   16'd1},
    {1'b0, 6'd16, 1'b0, 16'd3,     16'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mode;
  logic [K-1:0]  p_in;
  logic [K-1:0]  r_in;
  logic [ZW-1:0] z_in;
  logic          busy;
  logic          done;
  logic [K-1:0]  result;

  int n_checks;
  int n_fail;
  bit finished;

  modhalf_corr #(.K(K)) u_modhalf_corr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .p_in   (p_in),
    .r_in   (r_in),
    .z_in   (z_in),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint inv_mod(longint x, longint m);
    longint t0 = 0, t1 = 1, r0 = m, r1 = x % m, q, tmp;
    while (r1 != 0) begin
      q   = r0 / r1;
      tmp = r0 - q * r1; r0 = r1; r1 = tmp;
      tmp = t0 - q * t1; t0 = t1; t1 = tmp;
    end
    if (t0 < 0) t0 += m;
    return t0 % m;
  endfunction

  function automatic longint pow2_mod(int e, longint m);
    longint acc = 1 % m;
    for (int i = 0; i < e; i++) acc = (acc * 2) % m;
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Runs one operation; glitch >= 0 raises start with junk operands at that step.
  task automatic run_op(input logic m, input int z, input logic [K-1:0] r, input logic [K-1:0] p,
                        input int glitch, output logic [K-1:0] res, output int lat,
                        output bit busy_ok);
    @(negedge clk);
    start = 1'b1; mode = m; z_in = ZW'(z); r_in = r; p_in = p;
    @(posedge clk);
    @(negedge clk);
    start   = 1'b0;
    lat     = 0;
    busy_ok = 1'b1;
    while (!done && lat < 100) begin
      if (!busy) busy_ok = 1'b0;
      if (lat == glitch) begin
        start = 1'b1; r_in = 16'h1234; p_in = 16'd7; z_in = ZW'(2 * K); mode = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    res   = result;
    if (busy) busy_ok = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    summary();
  end

  initial begin
    logic [K-1:0] res;
    int           lat;
    bit           bok;
    longint       xinv, r, expv, p, x;
    int           z, nsteps;
    logic         m;
    logic [K-1:0] held;

    n_checks = 0; n_fail = 0; finished = 1'b0;
    start = 1'b0; mode = 1'b0; p_in = '0; r_in = '0; z_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
    check(result == '0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after reset", result, 0);

    // Table walk: classical and Montgomery-domain vectors
    for (int i = 0; i < NVEC; i++) begin
      m    = VEC[i][39];
      z    = int'(VEC[i][38:33]);
      p    = longint'(VEC[i][31:16]);
      x    = longint'(VEC[i][15:0]);
      xinv = inv_mod(x, p);
      r    = (xinv * pow2_mod(z, p)) % p;
      nsteps = m ? (z - K) : z;
      expv = m ? (xinv * pow2_mod(K, p)) % p : xinv;
      run_op(m, z, r[K-1:0], p[K-1:0], -1, res, lat, bok);
      check(longint'(res) == expv, m ? "R5 result value" : "R4 result value", res, expv);
      check(lat == nsteps, m ? "R5 step count" : "R4 step count", lat, nsteps);
      if (m)
        check((longint'(res) * x) % p == pow2_mod(K, p), "R5 product with x", (longint'(res) * x) % p, pow2_mod(K, p));
      else
        check((longint'(res) * x) % p == 1 % p, "R4 product with x", (longint'(res) * x) % p, 1);
      check(longint'(res) < p, "R10 result below p", res, p);
      if (nsteps > 0) check(bok, "R7 busy through run", bok, 1);
    end

    // R6: zero steps, pass-through, done right after start edge
    run_op(1'b1, K, 16'd4321, 16'd65521, -1, res, lat, bok);
    check(res == 16'd4321, "R6 pass-through value", res, 4321);
    check(lat == 0, "R6 done latency", lat, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle wide", done, 0);

    // R2: one even step
    run_op(1'b1, K + 1, 16'd100, 16'd65521, -1, res, lat, bok);
    check(res == 16'd50, "R2 even halving", res, 50);
    check(lat == 1, "R7 latency one step", lat, 1);
    // R3: odd step, sum exceeds K bits
    run_op(1'b1, K + 1, 16'd101, 16'd65521, -1, res, lat, bok);
    check(res == 16'd32811, "R3 odd halving", res, 32811);
    run_op(1'b1, K + 1, 16'd65519, 16'd65521, -1, res, lat, bok);
    check(res == 16'd65520, "R3 wide sum", res, 65520);

    // R8: result holds while inputs change and no start
    held = result;
    r_in = 16'hBEEF; p_in = 16'd9; mode = 1'b0; z_in = ZW'(K);
    repeat (6) @(negedge clk);
    check(result == held, "R8 result held", result, held);
    check(done == 1'b0, "R8 no done without start", done, 0);

    // R9: start during busy is ignored
    p    = 65521; x = 777;
    xinv = inv_mod(x, p);
    r    = (xinv * pow2_mod(2 * K, p)) % p;
    run_op(1'b0, 2 * K, r[K-1:0], p[K-1:0], 5, res, lat, bok);
    check(longint'(res) == xinv, "R9 result unaffected", res, xinv);
    check(lat == 2 * K, "R9 latency unaffected", lat, 2 * K);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 no extra run", {busy, done}, 0);

    summary();
  end
endmodule